// File: doc/BRIEF.md
# Interleaved Format Sector Number Generator

This block sequences one track-format operation on a hard-sectored disk with 19 physical slots per revolution. It decides which logical sector number goes into each physical slot, so that the finished track has the interleave the host asked for. A format is requested with a one-cycle `start` strobe. With the request come a start number (`offset`) and a 3-bit interleave selector (`ilv_code`). The block then follows the rotation using an index level and a sector strobe.

The format runs over three revolutions, each one opened by a falling edge of the index signal:

1. The first revolution erases the track, and `erase_gate` stays high for all of it.
2. The second revolution writes every other slot, starting at slot 0.
3. The third revolution writes the remaining slots.

The numbers come from one accumulator that runs on through both write revolutions. It starts at `offset`. It then steps by an increment chosen from `ilv_code` and wraps modulo 19.

Each slot to be written is flagged for one cycle on `slot_wr`, with the number on `sec_num`. The index edge that closes the third revolution produces a one-cycle `done`. A request with an out-of-range parameter raises `err` and starts nothing.

Top module: `fmt_secgen`

## Requirements
- R1: After reset, `busy`, `erase_gate`, `slot_wr`, `done` and `err` are 0 and `sec_num` is 0.
- R2: An accepted `start` (ilv_code 0..6 and offset 0..18, sampled while idle) sets `busy` on the next cycle. The block then waits for an index falling edge (index high in one cycle, low in the next). In the cycle after that edge `erase_gate` goes high, and it stays high until the cycle after the next index falling edge. No `slot_wr` occurs while idle, while waiting for the edge, or during the erase revolution.
- R3: Sector strobes are numbered 0, 1, 2, ... from the most recent index falling edge. In the first write revolution, strobes 0, 2, 4, ..., 18 each give a one-cycle `slot_wr` in the cycle after the strobe. Strobes 1, 3, ..., 17 give none.
- R4: The first `sec_num` written after the erase revolution equals `offset`.
- R5: Each later written number is the previous one plus the increment. The sum is reduced by subtracting 19 when it is 19 or more, so `sec_num` is always below 19. `sec_num` holds its last value between writes.
- R6: Interleave codes 0, 1, 2, 3, 4, 5, 6 select increments 2, 1, 7, 10, 8, 13, 3 (interleave 1:1 to 1:7). The 19 numbers written on a track are therefore all distinct.
- R7: In the second write revolution, strobes 1, 3, ..., 17 give `slot_wr` and strobes 0, 2, ..., 18 give none. The accumulator continues where the first write revolution left it. With code 2 and offset 0 the track reads 0, 13, 7, 1, 14, 8, 2, 15, 9, 3, 16, 10, 4, 17, 11, 5, 18, 12, 6 in slot order.
- R8: The index falling edge that ends the second write revolution gives `done` high for exactly one cycle, one cycle after the edge. `busy` falls in the same cycle.
- R9: A `start` with ilv_code 7 or offset above 18 sets `err` on the next cycle and leaves `busy`, `erase_gate` and `slot_wr` low. `err` stays set until the next accepted `start`.
- R10: A `start` while `busy` is ignored: the running format keeps its parameters and sequence.
- R11: A sector strobe does nothing in the same cycle as an index falling edge, nor beyond the 19th strobe of a revolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle format request |
| offset | input | 5 | Number for the first written slot |
| ilv_code | input | 3 | Interleave selector |
| index_lvl | input | 1 | Index signal; its falling edge opens a revolution |
| sector_strb | input | 1 | One-cycle slot boundary strobe |
| busy | output | 1 | Format in progress |
| erase_gate | output | 1 | Erase revolution active |
| slot_wr | output | 1 | Write this slot (one cycle) |
| sec_num | output | 5 | Sector number for the flagged slot |
| done | output | 1 | Format finished (one cycle) |
| err | output | 1 | Last request rejected |

## Verification
Every output is registered once behind the inputs. `busy` and `err` therefore change one cycle after `start`. `erase_gate` and `done` change one cycle after the index falling edge, and `slot_wr` with its `sec_num` follows one cycle after the strobe. The bench drives inputs on the falling clock edge and advances a behavioural model on the rising edge. It compares every output on the next falling edge, so each result is checked in exactly the cycle it is due. Whole-track results, namely the slot order for code 2 and the distinctness for every code, are checked when `done` arrives.

// File: rtl/fmtgen_pkg.sv
package fmtgen_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_ERASE,
      ST_PASS_A,
      ST_PASS_B
   } fmt_state_e;

   localparam int NUM_CODES = 7;

   // increment chosen by interleave selector; unused codes give 0
   function automatic int step_for_code(input logic [2:0] code);
      case (code)
         3'd0:    return 2;
         3'd1:    return 1;
         3'd2:    return 7;
         3'd3:    return 10;
         3'd4:    return 8;
         3'd5:    return 13;
         3'd6:    return 3;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/fmt_slot_track.sv
module fmt_slot_track #(
   parameter int N_SLOTS = 19,
   localparam int CW = $clog2(N_SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          index_lvl,
   input  logic          sector_strb,
   output logic          idx_fall,
   output logic          slot_hit,
   output logic [CW-1:0] slot_idx
);
   logic          idx_q;
   logic [CW-1:0] cnt;

   assign idx_fall = idx_q && !index_lvl;
   assign slot_hit = sector_strb && !idx_fall && (cnt < CW'(N_SLOTS));
   assign slot_idx = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= 1'b0;
         cnt   <= CW'(N_SLOTS);
      end else begin
         idx_q <= index_lvl;
         if (idx_fall)
            cnt <= '0;
         else if (slot_hit)
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/fmt_mod_step.sv
module fmt_mod_step #(
   parameter int N_SLOTS = 19,
   localparam int SW = $clog2(N_SLOTS)
) (
   input  logic [SW-1:0] acc,
   input  logic [2:0]    code,
   output logic [SW-1:0] nxt
);
   logic [SW:0] sum;

   always_comb sum = {1'b0, acc} + (SW+1)'(fmtgen_pkg::step_for_code(code));

   generate
      if ((1 << SW) == N_SLOTS) begin : g_pow2
         assign nxt = sum[SW-1:0];
      end else begin : g_sub
         assign nxt = (sum >= (SW+1)'(N_SLOTS)) ? SW'(sum - (SW+1)'(N_SLOTS))
                                                : sum[SW-1:0];
      end
   endgenerate
endmodule

// File: rtl/fmt_secgen.sv
module fmt_secgen #(
   parameter int N_SLOTS = 19,
   localparam int SW = $clog2(N_SLOTS),
   localparam int CW = $clog2(N_SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [SW-1:0] offset,
   input  logic [2:0]    ilv_code,
   input  logic          index_lvl,
   input  logic          sector_strb,
   output logic          busy,
   output logic          erase_gate,
   output logic          slot_wr,
   output logic [SW-1:0] sec_num,
   output logic          done,
   output logic          err
);
   import fmtgen_pkg::*;

   initial begin
      if (N_SLOTS < 14)
         $error("N_SLOTS must exceed the largest increment");
   end

   fmt_state_e    state;
   logic [SW-1:0] acc, off_q, acc_nxt;
   logic [2:0]    code_q;
   logic          idx_fall, slot_hit, req_ok, wr_now;
   logic [CW-1:0] slot_idx;

   fmt_slot_track #(.N_SLOTS(N_SLOTS)) u_track (
      .clk(clk), .rst_n(rst_n), .index_lvl(index_lvl),
      .sector_strb(sector_strb), .idx_fall(idx_fall),
      .slot_hit(slot_hit), .slot_idx(slot_idx)
   );

   fmt_mod_step #(.N_SLOTS(N_SLOTS)) u_step (
      .acc(acc), .code(code_q), .nxt(acc_nxt)
   );

   assign req_ok = (int'(ilv_code) < NUM_CODES) && (offset < SW'(N_SLOTS));
   assign wr_now = slot_hit &&
                   (((state == ST_PASS_A) && !slot_idx[0]) ||
                    ((state == ST_PASS_B) &&  slot_idx[0]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         acc        <= '0;
         off_q      <= '0;
         code_q     <= '0;
         busy       <= 1'b0;
         erase_gate <= 1'b0;
         slot_wr    <= 1'b0;
         sec_num    <= '0;
         done       <= 1'b0;
         err        <= 1'b0;
      end else begin
         slot_wr <= 1'b0;
         done    <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               err <= !req_ok;
               if (req_ok) begin
                  off_q  <= offset;
                  code_q <= ilv_code;
                  busy   <= 1'b1;
                  state  <= ST_ARM;
               end
            end
            ST_ARM: if (idx_fall) begin
               erase_gate <= 1'b1;
               state      <= ST_ERASE;
            end
            ST_ERASE: if (idx_fall) begin
               erase_gate <= 1'b0;
               acc        <= off_q;
               state      <= ST_PASS_A;
            end
            ST_PASS_A, ST_PASS_B: begin
               if (idx_fall) begin
                  if (state == ST_PASS_A) begin
                     state <= ST_PASS_B;
                  end else begin
                     state <= ST_IDLE;
                     busy  <= 1'b0;
                     done  <= 1'b1;
                  end
               end else if (wr_now) begin
                  slot_wr <= 1'b1;
                  sec_num <= acc;
                  acc     <= acc_nxt;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fmt_secgen_chk.sv
module fmt_secgen_chk #(
   parameter int N_SLOTS = 19,
   localparam int SW = $clog2(N_SLOTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sector_strb,
   input logic          busy,
   input logic          erase_gate,
   input logic          slot_wr,
   input logic [SW-1:0] sec_num,
   input logic          done,
   input logic          err
);
   AST_NO_WR_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr |-> !erase_gate); // R2
   AST_WR_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr |-> $past(sector_strb)); // R3
   AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr |-> (sec_num < SW'(N_SLOTS))); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !slot_wr && !erase_gate)); // R9
endmodule

bind fmt_secgen fmt_secgen_chk #(.N_SLOTS(N_SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sector_strb(sector_strb), .busy(busy),
   .erase_gate(erase_gate), .slot_wr(slot_wr), .sec_num(sec_num),
   .done(done), .err(err)
);

// File: tb/fmt_secgen_tb.sv
module fmt_secgen_tb;
   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [4:0] offset = '0;
   logic [2:0] ilv_code = '0;
   logic index_lvl = 1'b0, sector_strb = 1'b0;
   logic busy, erase_gate, slot_wr, done, err;
   logic [4:0] sec_num;

   int n_checks = 0, n_errs = 0, cycles = 0;

   fmt_secgen u_dut (.*);

   always #10 clk = ~clk;

   // behavioural reference
   int m_st = 0, m_slot = 19, m_acc = 0, m_off = 0, m_code = 0;
   int e_num = 0;
   bit m_idx = 0, e_busy = 0, e_erase = 0, e_wr = 0, e_done = 0, e_err = 0;
   int incs[7] = '{2, 1, 7, 10, 8, 13, 3};

   always @(posedge clk) begin
      bit fall;
      cycles++;
      if (!rst_n) begin
         m_st = 0; m_slot = 19; m_acc = 0; m_idx = 0;
         e_busy = 0; e_erase = 0; e_wr = 0; e_done = 0; e_err = 0; e_num = 0;
      end else begin
         fall = m_idx && !index_lvl;
         m_idx = index_lvl;
         e_wr = 0; e_done = 0;
         case (m_st)
            0: if (start) begin
               if (ilv_code > 6 || offset > 18) e_err = 1;
               else begin
                  e_err = 0; m_off = offset; m_code = ilv_code; e_busy = 1; m_st = 1;
               end
            end
            1: if (fall) begin e_erase = 1; m_st = 2; end
            2: if (fall) begin e_erase = 0; m_acc = m_off; m_st = 3; end
            default: if (fall) begin
               if (m_st == 3) m_st = 4;
               else begin m_st = 0; e_busy = 0; e_done = 1; end
            end else if (sector_strb && m_slot < 19) begin
               if ((m_slot % 2) == (m_st == 3 ? 0 : 1)) begin
                  e_wr = 1; e_num = m_acc;
                  m_acc = (m_acc + incs[m_code]) % 19;
               end
            end
         endcase
         if (fall) m_slot = 0;
         else if (sector_strb && m_slot < 19) m_slot++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // track log of written numbers in write order
   int wlog[$];
   always @(negedge clk) if (rst_n) begin
      chk(busy == e_busy, "R2 R10 busy", busy, e_busy);
      chk(erase_gate == e_erase, "R2 erase_gate", erase_gate, e_erase);
      chk(slot_wr == e_wr, "R3 R7 R11 slot_wr", slot_wr, e_wr);
      chk(int'(sec_num) == e_num, "R4 R5 R6 sec_num", sec_num, e_num);
      chk(done == e_done, "R8 done", done, e_done);
      chk(err == e_err, "R9 err", err, e_err);
      if (slot_wr) wlog.push_back(int'(sec_num));
   end

   task automatic rev(input int n_strb);
      index_lvl = 1'b1;
      repeat (3) @(negedge clk);
      index_lvl = 1'b0;
      for (int i = 0; i < n_strb; i++) begin
         repeat (2) @(negedge clk);
         sector_strb = 1'b1;
         @(negedge clk);
         sector_strb = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic go(input int code, input int off);
      @(negedge clk);
      start = 1'b1; ilv_code = 3'(code); offset = 5'(off);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic track(input int code, input int off, input int n_strb);
      int slots[19];
      bit seen[19];
      wlog.delete();
      go(code, off);
      rev(n_strb); rev(n_strb); rev(n_strb);
      index_lvl = 1'b1; @(negedge clk); index_lvl = 1'b0;
      repeat (3) @(negedge clk);
      chk(wlog.size() == 19, "R3 R7 write count", wlog.size(), 19);
      if (wlog.size() == 19) begin
         chk(wlog[0] == off, "R4 first number", wlog[0], off);
         for (int i = 0; i < 10; i++) slots[2*i] = wlog[i];
         for (int i = 0; i < 9; i++) slots[2*i+1] = wlog[10+i];
         foreach (seen[i]) seen[i] = 0;
         foreach (slots[i]) seen[slots[i]] = 1;
         foreach (seen[i]) chk(seen[i], "R6 distinct numbers", i, 1);
         if (code == 2 && off == 0) begin
            int exp_o[19] = '{0,13,7,1,14,8,2,15,9,3,16,10,4,17,11,5,18,12,6};
            foreach (exp_o[i]) chk(slots[i] == exp_o[i], "R7 slot order", slots[i], exp_o[i]);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !erase_gate && !slot_wr && !done && !err && sec_num == 0,
          "R1 reset state", {busy, erase_gate, slot_wr, done, err}, 0);
      // strobes while idle do nothing (R11)
      sector_strb = 1'b1; @(negedge clk); sector_strb = 1'b0;
      track(2, 0, 19);
      track(1, 0, 19);
      for (int c = 0; c < 7; c++) track(c, (c * 5 + 3) % 19, 19);
      track(5, 18, 19);
      track(3, 11, 22);            // R11 extra strobes
      go(7, 0); repeat (3) @(negedge clk);   // R9 bad code
      rev(19);
      go(2, 19); repeat (3) @(negedge clk);  // R9 bad offset
      // R10 start while busy
      wlog.delete();
      go(4, 6);
      rev(19);
      go(0, 1);
      rev(19); rev(19);
      index_lvl = 1'b1; @(negedge clk); index_lvl = 1'b0;
      repeat (3) @(negedge clk);
      chk(wlog.size() > 0 && wlog[0] == 6, "R10 parameters kept",
          wlog.size() > 0 ? wlog[0] : -1, 6);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_errs++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule